// File: doc/BRIEF.md
# Receive Word FIFO with Split Readout

This block sits between a serial line decoder and a CPU. The decoder delivers words of up to 11 bits, each with a parity verdict. Only words whose parity is good enter a three-entry first-in first-out store. The CPU reads the oldest stored word through two read views.

The byte view shows the low eight bits of the oldest word. The status view shows the remaining high bits. The status view is always visible and never changes the store. A byte read removes the oldest word, so software must take the status view first.

A pop qualifier lets compare or branch style accesses look at the byte without removing it. A select input switches the byte view over to an error code register. That register records a word that arrived while the store was full. A byte read taken while the error view is selected clears the register and leaves the store alone.

Top module: `rx_word_fifo`

## Requirements
- R1: A cycle with `rst` high at a clock edge empties the store and clears `dav`, `full` and the overflow error.
- R2: A word written with `wr_parity_ok` high is stored. From the next cycle `dav` is high, and while `sel_err` is low, bits 7:0 of the oldest word appear on `rd_byte` and bits 10:8 appear on `rd_stat`.
- R3: A word written with `wr_parity_ok` low is discarded. It does not change the store and does not set the overflow error.
- R4: Words leave in the order they were written. The store holds 3 words, and `full` is high exactly when 3 words are held.
- R5: A clock edge with `rd_data_en`, `rd_pop_en` and `dav` high and `sel_err` low removes the oldest word. `rd_stat` is a plain view and removes nothing.
- R6: With `rd_pop_en` low, `rd_data_en` removes nothing, and the same word stays on both views.
- R7: A good word that arrives while the store is full is dropped and sets the overflow error, unless a removal happens in the same cycle. In that case the word is accepted and `full` stays high.
- R8: While `sel_err` is high, `rd_byte` shows the error code register, with bit 0 = overflow and bits 7:1 = 0, and `rd_stat` reads 0. A `rd_data_en` in that state removes no word and clears the overflow error. A new overflow in the same cycle wins over the clear.
- R9: While the store is empty and `sel_err` is low, `rd_byte` and `rd_stat` read 0. A removal attempt on an empty store has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Decoder presents a word |
| wr_word | input | 11 | Decoded word |
| wr_parity_ok | input | 1 | Parity verdict for `wr_word` |
| rd_data_en | input | 1 | CPU reads the byte view |
| rd_pop_en | input | 1 | Byte read may remove the word |
| sel_err | input | 1 | Byte view shows the error code register |
| rd_byte | output | 8 | Byte view |
| rd_stat | output | 3 | Status view, high bits of the oldest word |
| dav | output | 1 | A word is waiting |
| full | output | 1 | Store holds 3 words |

## Verification
The hardest case to reach from the ports is a full store that receives a good word in the same cycle as a qualified byte read, together with the neighbouring cases where an overflow and an error-view read coincide. A directed sequence first fills the store and forces an overflow. It then inspects and clears the error view. Next it issues a write and a removal together while the store is full. Finally it drains the store past empty. After that, a long seeded random run keeps the store near full with frequent writes, and mixes in unqualified reads and error-view reads. Every cycle is compared against a queue model in the bench.

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
  parameter int WORD_W = 11,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              wr_parity_ok,
  input  logic              rd_data_en,
  input  logic              rd_pop_en,
  input  logic              sel_err,
  output logic [DATA_W-1:0] rd_byte,
  output logic [WORD_W-DATA_W-1:0] rd_stat,
  output logic              dav,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  count;
  logic              ovf;

  wire pop   = rd_data_en & rd_pop_en & ~sel_err & (count != '0);
  wire wr_ok = wr_en & wr_parity_ok;
  wire push  = wr_ok & ((count != CNT_W'(DEPTH)) | pop);
  wire [WORD_W-1:0] head = mem[rp];

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push) begin
        mem[wp] <= wr_word;
        wp      <= inc(wp);
      end
      if (pop) rp <= inc(rp);
      count <= count + CNT_W'(push) - CNT_W'(pop);
      if (wr_ok && !push)              ovf <= 1'b1;
      else if (rd_data_en && sel_err)  ovf <= 1'b0;
    end
  end

  assign dav     = (count != '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign rd_byte = sel_err ? DATA_W'(ovf) : (dav ? head[DATA_W-1:0] : '0);
  assign rd_stat = (sel_err || !dav) ? '0 : head[WORD_W-1:DATA_W];

  AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    full |-> dav); // R4

  AST_NO_POP_UNQUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (rd_data_en && !rd_pop_en && !wr_en) |=> $stable(count)); // R6

  AST_BAD_PARITY_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_parity_ok && !rd_data_en) |=> ($stable(count) && $stable(ovf))); // R3

  AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && wr_parity_ok && !(rd_data_en && rd_pop_en && !sel_err)) |=> (ovf && full)); // R7

  AST_ERR_VIEW_NO_POP: assert property (@(posedge clk) disable iff (rst)
    (sel_err && !wr_en) |=> $stable(count)); // R8

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!dav && !sel_err) |-> (rd_byte == '0 && rd_stat == '0)); // R9
endmodule

// File: tb/rx_word_fifo_tb.sv
module rx_word_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 3;

  logic clk = 1'b0;
  logic rst, wr_en, wr_parity_ok, rd_data_en, rd_pop_en, sel_err;
  logic [10:0] wr_word;
  logic [7:0]  rd_byte;
  logic [2:0]  rd_stat;
  logic        dav, full;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  logic [10:0] mq[$];
  logic        m_ovf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_word_fifo u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
    .wr_parity_ok(wr_parity_ok), .rd_data_en(rd_data_en),
    .rd_pop_en(rd_pop_en), .sel_err(sel_err), .rd_byte(rd_byte),
    .rd_stat(rd_stat), .dav(dav), .full(full));

  function automatic logic [7:0] exp_byte();
    if (sel_err) return {7'b0, m_ovf};
    if (mq.size() == 0) return 8'h00;
    return mq[0][7:0];
  endfunction

  function automatic logic [2:0] exp_stat();
    if (sel_err || mq.size() == 0) return 3'b000;
    return mq[0][10:8];
  endfunction

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic model_step();
    bit pop, wok, acc;
    if (rst) begin
      mq.delete();
      m_ovf = 1'b0;
      return;
    end
    pop = rd_data_en && rd_pop_en && !sel_err && mq.size() > 0;
    wok = wr_en && wr_parity_ok;
    acc = wok && (mq.size() < DEPTH || pop);
    if (pop) void'(mq.pop_front());
    if (acc) mq.push_back(wr_word);
    if (wok && !acc) m_ovf = 1'b1;
    else if (rd_data_en && sel_err) m_ovf = 1'b0;
  endtask

  task automatic cyc(input bit r, input bit w, input logic [10:0] word, input bit par,
                     input bit rd, input bit q, input bit se);
    @(negedge clk);
    rst = r; wr_en = w; wr_word = word; wr_parity_ok = par;
    rd_data_en = rd; rd_pop_en = q; sel_err = se;
    @(posedge clk);
    #1;
    model_step();
    chk("dav", dav, mq.size() > 0);
    chk("full", full, mq.size() == DEPTH);
    chk("rd_byte", rd_byte, exp_byte());
    chk("rd_stat", rd_stat, exp_stat());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tag = "R1";
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 11'h7FF, 1, 0, 0, 0);
    tag = "R2";
    cyc(0, 1, 11'h5A3, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    tag = "R6";
    cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    tag = "R5";
    cyc(0, 0, 0, 0, 1, 1, 0);
    tag = "R3";
    cyc(0, 1, 11'h123, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    tag = "R4";
    cyc(0, 1, 11'h101, 1, 0, 0, 0);
    cyc(0, 1, 11'h202, 1, 0, 0, 0);
    cyc(0, 1, 11'h303, 1, 0, 0, 0);
    tag = "R7";
    cyc(0, 1, 11'h4FF, 1, 0, 0, 0);
    tag = "R8";
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 1, 11'h0EE, 1, 1, 1, 1);
    cyc(0, 0, 0, 0, 1, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    tag = "R7";
    cyc(0, 1, 11'h6CD, 1, 1, 1, 0);
    tag = "R4";
    cyc(0, 0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 1, 1, 0);
    tag = "R9";
    cyc(0, 0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    tag = "R1";
    cyc(0, 1, 11'h111, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 200) == 0,
          ($urandom % 100) < 60,
          11'($urandom),
          ($urandom % 100) < 85,
          ($urandom % 100) < 45,
          ($urandom % 100) < 80,
          ($urandom % 100) < 10);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule